// File: doc/BRIEF.md
# Best-Effort Transactional Cache Tracker

This block sits in front of a small data cache and gives the core best-effort hardware transactions. A begin command opens a transaction and stores a fail address. While the transaction runs, reads set a read mark on the touched line. Writes set a written mark and keep the new value in a speculative copy held next to the line. The first write to each line appends that line to a bounded commit list. Memory sees none of these values until commit.

A commit command drains the commit list to the memory write port, one line per cycle and in the order the lines were first written. When the list is empty the transaction is reported complete. An abort discards all speculative values, marks and list entries and redirects the core to the stored fail address. An abort is caused by a coherence invalidation that hits a marked line, by running out of commit-list space, by a trap-class event (interrupt, exception, translation miss, branch mispredict), or by an unsupported instruction. The abort causes are kept in a status word that the core can read. Outside a transaction, writes go to the line and to memory at once.

Top module: `tx_cache_tracker`

## Requirements
- R1: When no transaction is open, a core write (coreValid and coreWrite) is shown on the memory write port in the same cycle and updates the line at the next clock edge. coreRdata always shows the current value of the line at coreAddr, combinationally.
- R2: A begin command while idle stores cmdFailAddr, raises inTxn from the next cycle and clears abortStatus to zero. A begin command while a transaction or a drain is in progress is ignored.
- R3: Inside a transaction, a write keeps its value locally. coreRdata returns the new value, the memory write port stays idle, and the value from before the transaction is kept for a possible abort.
- R4: The first write to each line in a transaction appends that line to the commit list. After a commit command, busy is high and the list is written to memory one line per cycle, in order of first write, with the speculative value. A core access made in the same cycle as the commit command is dropped.
- R5: commitDone pulses for one cycle after the cycle that follows the last write-back. In that same cycle busy and inTxn are low, and the committed values are read back from the lines.
- R6: Inside a transaction, an invalidation whose address hits a read-marked or written-marked line aborts with abortStatus bit 0 (conflict). An invalidation of an unmarked line, an invalidation outside a transaction, and an invalidation during a drain have no effect.
- R7: A write that needs a new commit-list entry while the list already holds CB_DEPTH entries aborts with abortStatus bit 1 (capacity). A write to a line already in the list is still accepted.
- R8: Inside a transaction, trapEvt aborts with abortStatus bit 2 and unsupEvt aborts with bit 3. Every cause present in the abort cycle is recorded. A core access or commit command in that cycle is dropped.
- R9: After an abort, redirectValid pulses for one cycle in the next cycle, with redirectAddr equal to the stored fail address. In that same cycle inTxn is low and every speculative value and mark is gone, so reads return the values from before the transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdBegin | input | 1 | Open a transaction |
| cmdFailAddr | input | PC_W | Fail address stored at begin |
| cmdCommit | input | 1 | Commit the open transaction |
| coreValid | input | 1 | Core access strobe |
| coreWrite | input | 1 | Access is a write |
| coreAddr | input | $clog2(NUM_LINES) | Line index of the access |
| coreWdata | input | DATA_W | Write data |
| coreRdata | output | DATA_W | Read data of the line at coreAddr |
| invValid | input | 1 | Coherence invalidation strobe |
| invAddr | input | $clog2(NUM_LINES) | Invalidated line index |
| trapEvt | input | 1 | Interrupt, exception, translation miss or mispredict |
| unsupEvt | input | 1 | Unsupported instruction seen |
| inTxn | output | 1 | Transaction open |
| busy | output | 1 | Commit drain in progress |
| commitDone | output | 1 | One-cycle commit-complete pulse |
| redirectValid | output | 1 | One-cycle abort redirect pulse |
| redirectAddr | output | PC_W | Fail address of the aborted transaction |
| abortStatus | output | 4 | Cause bits: 0 conflict, 1 capacity, 2 trap, 3 unsupported |
| memWrValid | output | 1 | Memory write strobe |
| memWrAddr | output | $clog2(NUM_LINES) | Memory write line index |
| memWrData | output | DATA_W | Memory write data |

## Verification
The bench builds the tracker with 8 lines, a 4-entry commit list and 16-bit data and fail addresses. With only four entries, a capacity abort takes only five distinct writes. Eight lines still leave room for marked and unmarked lines side by side, so conflicting and harmless invalidations can be tried in the same transaction. The narrow widths keep the behavioural model's arrays small. The default 16-entry list reaches its capacity abort through the same path, only after more writes.

// File: rtl/tx_pkg.sv
package tx_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_TXN, ST_DRAIN} txState_e;

  typedef struct packed {
    logic plainWr;
    logic specWr;
    logic markRd;
    logic drainStep;
    logic discard;
  } txStrobe_t;

  localparam int CAUSE_W        = 4;
  localparam int CAUSE_CONFLICT = 0;
  localparam int CAUSE_CAPACITY = 1;
  localparam int CAUSE_TRAP     = 2;
  localparam int CAUSE_UNSUP    = 3;
endpackage

// File: rtl/tx_datapath.sv
module tx_datapath import tx_pkg::*; #(
  parameter int NUM_LINES = 64,
  parameter int DATA_W    = 32,
  parameter int CB_DEPTH  = 16,
  localparam int IDX_W    = $clog2(NUM_LINES),
  localparam int CNT_W    = $clog2(CB_DEPTH + 1),
  localparam int LIST_IW  = $clog2(CB_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         stb,
  input  logic [IDX_W-1:0]  accAddr,
  input  logic [DATA_W-1:0] accWdata,
  input  logic [IDX_W-1:0]  invAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              accSpecW,
  output logic              invHit,
  output logic              listFull,
  output logic              drainPending,
  output logic [IDX_W-1:0]  drainAddr,
  output logic [DATA_W-1:0] drainData,
  output logic              anyMark
);
  logic [DATA_W-1:0]    lineData [NUM_LINES];
  logic [DATA_W-1:0]    specData [NUM_LINES];
  logic [NUM_LINES-1:0] specR, specW;
  logic [IDX_W-1:0]     cbList [CB_DEPTH];
  logic [CNT_W-1:0]     cbCount, drainIdx;

  assign rdData       = specW[accAddr] ? specData[accAddr] : lineData[accAddr];
  assign accSpecW     = specW[accAddr];
  assign invHit       = specR[invAddr] | specW[invAddr];
  assign listFull     = (cbCount == CNT_W'(CB_DEPTH));
  assign drainPending = (drainIdx < cbCount);
  assign drainAddr    = cbList[drainIdx[LIST_IW-1:0]];
  assign drainData    = specData[drainAddr];
  assign anyMark      = (|specR) | (|specW);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_LINES; i++) begin
        lineData[i] <= '0;
        specData[i] <= '0;
      end
      for (int j = 0; j < CB_DEPTH; j++) cbList[j] <= '0;
      specR    <= '0;
      specW    <= '0;
      cbCount  <= '0;
      drainIdx <= '0;
    end else begin
      if (stb.plainWr) lineData[accAddr] <= accWdata;
      if (stb.specWr) begin
        specData[accAddr] <= accWdata;
        specW[accAddr]    <= 1'b1;
        if (!specW[accAddr]) begin
          cbList[cbCount[LIST_IW-1:0]] <= accAddr;
          cbCount <= cbCount + 1'b1;
        end
      end
      if (stb.markRd) specR[accAddr] <= 1'b1;
      if (stb.drainStep) begin
        lineData[drainAddr] <= drainData;
        drainIdx <= drainIdx + 1'b1;
      end
      if (stb.discard) begin
        specR    <= '0;
        specW    <= '0;
        cbCount  <= '0;
        drainIdx <= '0;
      end
    end
  end

  a_r4_list_bound: assert property (@(posedge clk) disable iff (!rstN)
    cbCount <= CNT_W'(CB_DEPTH));
  a_r7_no_push_when_full: assert property (@(posedge clk) disable iff (!rstN)
    (stb.specWr && !specW[accAddr]) |-> !listFull);
  a_r4_drain_walks: assert property (@(posedge clk) disable iff (!rstN)
    (stb.drainStep && !stb.discard) |=> (drainIdx == $past(drainIdx) + 1'b1));
endmodule

// File: rtl/tx_ctrl.sv
module tx_ctrl import tx_pkg::*; #(
  parameter int PC_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdBegin,
  input  logic [PC_W-1:0]    cmdFailAddr,
  input  logic               cmdCommit,
  input  logic               coreValid,
  input  logic               coreWrite,
  input  logic               invValid,
  input  logic               trapEvt,
  input  logic               unsupEvt,
  input  logic               invHit,
  input  logic               accSpecW,
  input  logic               listFull,
  input  logic               drainPending,
  output txStrobe_t          stb,
  output logic               inTxn,
  output logic               busy,
  output logic               commitDone,
  output logic               redirectValid,
  output logic [PC_W-1:0]    redirectAddr,
  output logic [CAUSE_W-1:0] abortStatus
);
  txState_e           state;
  logic [PC_W-1:0]    failAddrQ;
  logic [CAUSE_W-1:0] causes;
  logic               abortNow, inTxnQ, accOk;

  assign inTxnQ = (state == ST_TXN);
  assign inTxn  = inTxnQ;
  assign busy   = (state == ST_DRAIN);

  always_comb begin
    causes                 = '0;
    causes[CAUSE_CONFLICT] = invValid && invHit;
    causes[CAUSE_CAPACITY] = coreValid && coreWrite && !accSpecW && listFull;
    causes[CAUSE_TRAP]     = trapEvt;
    causes[CAUSE_UNSUP]    = unsupEvt;
  end

  assign abortNow = inTxnQ && (|causes);
  assign accOk    = inTxnQ && !abortNow && !cmdCommit && coreValid;

  always_comb begin
    stb           = '0;
    stb.plainWr   = (state == ST_IDLE) && coreValid && coreWrite;
    stb.specWr    = accOk && coreWrite;
    stb.markRd    = accOk && !coreWrite;
    stb.drainStep = busy && drainPending;
    stb.discard   = abortNow || (busy && !drainPending);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state         <= ST_IDLE;
      failAddrQ     <= '0;
      redirectAddr  <= '0;
      abortStatus   <= '0;
      redirectValid <= 1'b0;
      commitDone    <= 1'b0;
    end else begin
      redirectValid <= abortNow;
      commitDone    <= busy && !drainPending;
      case (state)
        ST_IDLE: if (cmdBegin) begin
          state       <= ST_TXN;
          failAddrQ   <= cmdFailAddr;
          abortStatus <= '0;
        end
        ST_TXN: if (abortNow) begin
          state        <= ST_IDLE;
          abortStatus  <= causes;
          redirectAddr <= failAddrQ;
        end else if (cmdCommit) begin
          state <= ST_DRAIN;
        end
        ST_DRAIN: if (!drainPending) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  a_r9_redirect_pulse: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |=> !redirectValid);
  a_r8_abort_has_cause: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |-> (abortStatus != '0 && !inTxnQ));
  a_r2_begin_clears: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && cmdBegin) |=> (abortStatus == '0 && inTxnQ));
  a_r5_done_after_drain: assert property (@(posedge clk) disable iff (!rstN)
    commitDone |-> ($past(busy) && state == ST_IDLE));
  a_r6_drain_no_abort: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !redirectValid);
endmodule

// File: rtl/tx_cache_tracker.sv
module tx_cache_tracker import tx_pkg::*; #(
  parameter int NUM_LINES = 64,
  parameter int DATA_W    = 32,
  parameter int CB_DEPTH  = 16,
  parameter int PC_W      = 32,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdBegin,
  input  logic [PC_W-1:0]   cmdFailAddr,
  input  logic              cmdCommit,
  input  logic              coreValid,
  input  logic              coreWrite,
  input  logic [IDX_W-1:0]  coreAddr,
  input  logic [DATA_W-1:0] coreWdata,
  output logic [DATA_W-1:0] coreRdata,
  input  logic              invValid,
  input  logic [IDX_W-1:0]  invAddr,
  input  logic              trapEvt,
  input  logic              unsupEvt,
  output logic              inTxn,
  output logic              busy,
  output logic              commitDone,
  output logic              redirectValid,
  output logic [PC_W-1:0]   redirectAddr,
  output logic [3:0]        abortStatus,
  output logic              memWrValid,
  output logic [IDX_W-1:0]  memWrAddr,
  output logic [DATA_W-1:0] memWrData
);
  txStrobe_t         stb;
  logic              accSpecW, invHit, listFull, drainPending, anyMark;
  logic [IDX_W-1:0]  drainAddr;
  logic [DATA_W-1:0] drainData;

  tx_ctrl #(.PC_W(PC_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdBegin(cmdBegin), .cmdFailAddr(cmdFailAddr),
    .cmdCommit(cmdCommit), .coreValid(coreValid), .coreWrite(coreWrite),
    .invValid(invValid), .trapEvt(trapEvt), .unsupEvt(unsupEvt),
    .invHit(invHit), .accSpecW(accSpecW), .listFull(listFull),
    .drainPending(drainPending), .stb(stb), .inTxn(inTxn), .busy(busy),
    .commitDone(commitDone), .redirectValid(redirectValid),
    .redirectAddr(redirectAddr), .abortStatus(abortStatus)
  );

  tx_datapath #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W), .CB_DEPTH(CB_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .accAddr(coreAddr), .accWdata(coreWdata),
    .invAddr(invAddr), .rdData(coreRdata), .accSpecW(accSpecW), .invHit(invHit),
    .listFull(listFull), .drainPending(drainPending), .drainAddr(drainAddr),
    .drainData(drainData), .anyMark(anyMark)
  );

  assign memWrValid = stb.plainWr | stb.drainStep;
  assign memWrAddr  = stb.drainStep ? drainAddr : coreAddr;
  assign memWrData  = stb.drainStep ? drainData : coreWdata;

  a_r9_clean_on_redirect: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |-> !anyMark);
  a_r5_clean_on_done: assert property (@(posedge clk) disable iff (!rstN)
    commitDone |-> (!anyMark && !busy));
  a_r3_no_mem_in_txn: assert property (@(posedge clk) disable iff (!rstN)
    inTxn |-> !memWrValid);
endmodule

// File: tb/tx_cache_tracker_bench.sv
`timescale 1ns/100ps
module tx_cache_tracker_bench;
  localparam int NL = 8, DW = 16, CBD = 4, PW = 16;

  logic clk = 1'b0, rstN = 1'b0;
  logic cmdBegin = 0, cmdCommit = 0, coreValid = 0, coreWrite = 0;
  logic invValid = 0, trapEvt = 0, unsupEvt = 0;
  logic [PW-1:0] cmdFailAddr = '0;
  logic [2:0] coreAddr = '0, invAddr = '0;
  logic [DW-1:0] coreWdata = '0;
  logic [DW-1:0] coreRdata, memWrData, redirectAddr_unused;
  logic inTxn, busy, commitDone, redirectValid, memWrValid;
  logic [PW-1:0] redirectAddr;
  logic [3:0] abortStatus;
  logic [2:0] memWrAddr;

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  tx_cache_tracker #(.NUM_LINES(NL), .DATA_W(DW), .CB_DEPTH(CBD), .PC_W(PW)) u_tx_cache_tracker (
    .clk(clk), .rstN(rstN), .cmdBegin(cmdBegin), .cmdFailAddr(cmdFailAddr),
    .cmdCommit(cmdCommit), .coreValid(coreValid), .coreWrite(coreWrite),
    .coreAddr(coreAddr), .coreWdata(coreWdata), .coreRdata(coreRdata),
    .invValid(invValid), .invAddr(invAddr), .trapEvt(trapEvt), .unsupEvt(unsupEvt),
    .inTxn(inTxn), .busy(busy), .commitDone(commitDone), .redirectValid(redirectValid),
    .redirectAddr(redirectAddr), .abortStatus(abortStatus), .memWrValid(memWrValid),
    .memWrAddr(memWrAddr), .memWrData(memWrData)
  );
  assign redirectAddr_unused = '0;

  // Behavioural reference model: 0 idle, 1 transaction, 2 draining
  int mSt = 0, mIdx = 0, mFail = 0, mStat = 0, mRedirAddr = 0;
  bit mRedir = 0, mDone = 0;
  int mData [NL], mSpec [NL];
  bit mR [NL], mW [NL];
  int mList [$];

  task automatic check(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mSt = 0; mIdx = 0; mFail = 0; mStat = 0; mRedirAddr = 0; mRedir = 0; mDone = 0;
      foreach (mData[i]) begin mData[i] = 0; mSpec[i] = 0; mR[i] = 0; mW[i] = 0; end
      mList.delete();
    end else begin
      int a;
      int c;
      a = int'(coreAddr);
      mRedir = 0; mDone = 0;
      if (mSt == 0) begin
        if (coreValid && coreWrite) mData[a] = int'(coreWdata);
        if (cmdBegin) begin mSt = 1; mFail = int'(cmdFailAddr); mStat = 0; end
      end else if (mSt == 1) begin
        c = 0;
        if (invValid && (mR[invAddr] || mW[invAddr])) c |= 1;
        if (coreValid && coreWrite && !mW[a] && mList.size() == CBD) c |= 2;
        if (trapEvt) c |= 4;
        if (unsupEvt) c |= 8;
        if (c != 0) begin
          mStat = c; mRedir = 1; mRedirAddr = mFail; mSt = 0;
          foreach (mR[i]) begin mR[i] = 0; mW[i] = 0; end
          mList.delete();
        end else if (cmdCommit) begin
          mSt = 2; mIdx = 0;
        end else if (coreValid) begin
          if (coreWrite) begin
            if (!mW[a]) mList.push_back(a);
            mW[a] = 1; mSpec[a] = int'(coreWdata);
          end else mR[a] = 1;
        end
      end else begin
        if (mIdx < mList.size()) begin
          mData[mList[mIdx]] = mSpec[mList[mIdx]]; mIdx++;
        end else begin
          mSt = 0; mDone = 1; mIdx = 0; mList.delete();
          foreach (mR[i]) begin mR[i] = 0; mW[i] = 0; end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rstN && !finished) begin
      int a;
      bit ev;
      int ea;
      int ed;
      a = int'(coreAddr);
      ev = 0; ea = 0; ed = 0;
      if (mSt == 2 && mIdx < mList.size()) begin
        ev = 1; ea = mList[mIdx]; ed = mSpec[ea];
      end else if (mSt == 0 && coreValid && coreWrite) begin
        ev = 1; ea = a; ed = int'(coreWdata);
      end
      check("R1/R3 coreRdata", int'(coreRdata), mW[a] ? mSpec[a] : mData[a]);
      check("R2 inTxn", int'(inTxn), int'(mSt == 1));
      check("R4 busy", int'(busy), int'(mSt == 2));
      check("R1/R4 memWrValid", int'(memWrValid), int'(ev));
      if (ev) begin
        check("R4 memWrAddr", int'(memWrAddr), ea);
        check("R4 memWrData", int'(memWrData), ed);
      end
      check("R5 commitDone", int'(commitDone), int'(mDone));
      check("R9 redirectValid", int'(redirectValid), int'(mRedir));
      if (mRedir) check("R9 redirectAddr", int'(redirectAddr), mRedirAddr);
      check("R6/R7/R8 abortStatus", int'(abortStatus), mStat);
    end
  end

  task automatic cyc();
    @(posedge clk); #1;
    cmdBegin = 0; cmdCommit = 0; coreValid = 0; coreWrite = 0;
    invValid = 0; trapEvt = 0; unsupEvt = 0;
  endtask
  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask
  task automatic wr(int a, int d);
    coreValid = 1; coreWrite = 1; coreAddr = 3'(a); coreWdata = DW'(d); cyc();
  endtask
  task automatic rd(int a);
    coreValid = 1; coreWrite = 0; coreAddr = 3'(a); cyc();
  endtask
  task automatic bgn(int pc);
    cmdBegin = 1; cmdFailAddr = PW'(pc); cyc();
  endtask
  task automatic inv(int a);
    invValid = 1; invAddr = 3'(a); cyc();
  endtask

  initial begin
    idle(3);
    rstN = 1; cyc();
    // R1: plain writes and reads
    for (int i = 0; i < NL; i++) wr(i, 16'h100 + i);
    for (int i = 0; i < NL; i++) rd(i);
    // R2 R3 R4 R5: transaction with commit, drain order 2 then 6
    bgn(16'h40);
    wr(2, 16'hAAAA); rd(2); rd(5); wr(6, 16'h6666); wr(2, 16'hBBBB);
    cmdCommit = 1; coreValid = 1; coreWrite = 1; coreAddr = 3; coreWdata = 16'hDEAD; cyc();
    idle(5); rd(2); rd(3); rd(6);
    // R6: harmless invalidation, then conflict on written line
    bgn(16'h41); wr(1, 16'h1111); inv(3); rd(1); inv(1); idle(2); rd(1);
    // R6: conflict on read-marked line; invalidation outside txn
    bgn(16'h42); rd(4); inv(4); idle(1); inv(4); idle(1);
    // R7: capacity abort after CBD new lines
    bgn(16'h43);
    for (int i = 0; i < CBD; i++) wr(i, 16'h3000 + i);
    wr(2, 16'h3333); wr(4, 16'h3004); idle(2);
    for (int i = 0; i <= CBD; i++) rd(i);
    // R6: invalidations during drain ignored
    bgn(16'h44);
    for (int i = 0; i < CBD; i++) wr(i, 16'h4000 + i);
    cmdCommit = 1; cyc(); inv(0); inv(1); idle(5);
    // R8: trap and unsupported together, access dropped
    bgn(16'h45); wr(5, 16'h5555);
    trapEvt = 1; unsupEvt = 1; coreValid = 1; coreWrite = 1; coreAddr = 6; coreWdata = 16'h9999; cyc();
    idle(1); rd(5); rd(6);
    // R8: unsupported alone
    bgn(16'h46); unsupEvt = 1; cyc(); idle(1);
    // R8: trap alone with same-cycle commit dropped; R2 clear on begin
    bgn(16'h47); wr(7, 16'h7777); trapEvt = 1; cmdCommit = 1; cyc(); idle(2);
    // R2: begin during txn ignored, fail address kept
    bgn(16'h48); bgn(16'h49); wr(7, 16'h7070); trapEvt = 1; cyc(); idle(2);
    // R5: empty commit
    bgn(16'h4A); cmdCommit = 1; cyc(); idle(3);
    // R2: begin during drain ignored
    bgn(16'h4B); wr(3, 16'hC3C3); cmdCommit = 1; cyc(); bgn(16'h4C); idle(4);
    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule